// File: doc/BRIEF.md
# Interrupt Source State Controller

This block is the source stage of a two-stage interrupt controller. It keeps per-source state for a parameterised number of interrupt inputs. Each source is either edge-signalled (message) or level-signalled, and the parameter `LEVEL_MASK` fixes which. It turns raw request lines and configuration writes into offers for a presentation stage. Each offer carries a target server, a global source number and a priority. The presentation stage answers with reject and end-of-interrupt (EOI) pulses that carry a global source number, and with a resend pulse that asks for rejected or unsent work to be replayed.

Each source holds a server number, an 8-bit priority and an 8-bit saved priority. A priority of 0xFF masks the source. Each source also holds four status flags. Level sources use `asserted` and `sent`. Message sources use `rejected` and `mask_pend`. Pending offers from all sources go to a lowest-index-first arbiter, which issues at most one registered offer per clock.

A small state machine runs the resend walk. It has two states. `SC_IDLE` waits for a resend pulse. `SC_WALK` visits one source per clock in ascending index order. Its transitions are:
- IDLE→WALK when a resend pulse arrives.
- WALK→WALK with the pointer advanced on each cycle.
- WALK→WALK with the pointer restarted at 0 when a resend arrives during the walk.
- WALK→IDLE after the last source has been visited.

Top module: `irq_src_ctl`

## Requirements
- R1: After reset, every source has priority 0xFF (masked), server 0 and all status flags clear, and `offer_valid` is low. A source's type comes only from `LEVEL_MASK` and is not changed by reset.
- R2: A rising edge on the input of an unmasked message source gives an offer two clocks after the edge is presented. The offer carries that source's server, its priority, and the number `BASE`+index. Holding the input high gives no further offer.
- R3: A rising edge on a masked message source produces no offer and sets `mask_pend`. A later configuration write with a priority other than 0xFF clears `mask_pend` and produces an offer one clock after the write cycle.
- R4: On a level source, `asserted` follows the input. Each input change, each configuration write and each resend visit re-evaluates the source. If the source is unmasked, asserted and not sent, the evaluation sets `sent` and makes one offer.
- R5: An EOI to a level source clears `sent` but does not offer by itself. An EOI to a message source has no effect.
- R6: A reject to a message source sets `rejected`. A reject to a level source clears `sent`.
- R7: A resend walks the sources one per clock starting at index 0, so source k is offered `k+3` clocks after the resend cycle. A message source with `rejected` set has the flag cleared and is re-offered if unmasked. A resend that arrives during a walk restarts the walk at index 0.
- R8: At most one offer leaves per clock. When several sources are pending, the lowest index goes first.
- R9: Reject and EOI act only on the source whose global number equals `BASE`+index. A number outside the range `BASE`..`BASE`+`NUM_SRC`-1 is ignored.
- R10: A configuration write that masks a source whose offer is still queued cancels that offer. A message source then sets `mask_pend`. A level source clears `sent`.
- R11: A configuration write stores the server, the priority and the saved priority of the addressed source.
- R12: Bit i of `LEVEL_MASK` set to 1 makes source i a level source. After a level source has been offered, lowering and raising its input gives no new offer until `sent` is cleared. A message source, by contrast, is offered again on each new rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_SRC | Raw request line of each source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Local index of the source being configured |
| cfg_server | input | SRV_W | Target server to store |
| cfg_prio | input | 8 | Priority to store (0xFF masks the source) |
| cfg_saved | input | 8 | Saved priority to store |
| rej_valid | input | 1 | Reject pulse from the presentation stage |
| rej_num | input | NUM_W | Global number of the rejected source |
| eoi_valid | input | 1 | End-of-interrupt pulse |
| eoi_num | input | NUM_W | Global number of the completed source |
| resend | input | 1 | Resend request pulse |
| offer_valid | output | 1 | An offer is presented this cycle |
| offer_server | output | SRV_W | Server that the offer targets |
| offer_num | output | NUM_W | Global source number of the offer |
| offer_prio | output | 8 | Priority of the offer |

## Verification
The bench builds the block with its defaults: eight sources, with `LEVEL_MASK` = 0xF0 so that sources 0–3 are message sources and sources 4–7 are level sources, `BASE` = 0x1000, 4-bit servers and 24-bit numbers. Eight sources keep the resend walk short enough to measure its exact per-index latency. That length still allows simultaneous requests to be ordered and a walk to be restarted partway through. A number of 0x1008 aliases source 0 in its low bits, so it shows whether out-of-range rejects are really ignored.

// File: rtl/irqsrc_pkg.sv
package irqsrc_pkg;
    localparam logic [7:0] PRIO_MASKED = 8'hFF;

    typedef struct packed {
        logic asserted;
        logic sent;
        logic rejected;
        logic mask_pend;
    } src_stat_t;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_WALK = 1'b1
    } scan_state_t;
endpackage

// File: rtl/irqsrc_slot.sv
module irqsrc_slot
    import irqsrc_pkg::*;
#(
    parameter int SRV_W    = 4,
    parameter bit IS_LEVEL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq,
    input  logic             cfg_hit,
    input  logic [SRV_W-1:0] cfg_server,
    input  logic [7:0]       cfg_prio,
    input  logic [7:0]       cfg_saved,
    input  logic             rej_hit,
    input  logic             eoi_hit,
    input  logic             scan_hit,
    input  logic             grant,
    output logic             req,
    output logic [SRV_W-1:0] server,
    output logic [7:0]       prio,
    output logic [7:0]       saved
);
    src_stat_t        stat_q, stat_d;
    logic             req_d;
    logic [SRV_W-1:0] srv_d;
    logic [7:0]       prio_d, saved_d;
    logic             irq_q;
    logic             masked;
    logic             eval;

    always_comb begin
        srv_d   = server;
        prio_d  = prio;
        saved_d = saved;
        stat_d  = stat_q;
        req_d   = req & ~grant;
        eval    = 1'b0;
        if (cfg_hit) begin
            srv_d   = cfg_server;
            prio_d  = cfg_prio;
            saved_d = cfg_saved;
        end
        masked = (prio_d == PRIO_MASKED);
        if (IS_LEVEL) begin
            eval            = (irq != stat_q.asserted) | cfg_hit | scan_hit;
            stat_d.asserted = irq;
            if (rej_hit || eoi_hit)
                stat_d.sent = 1'b0;
            if (masked && req_d) begin
                req_d       = 1'b0;
                stat_d.sent = 1'b0;
            end
            if (eval && !masked && irq && !stat_d.sent) begin
                stat_d.sent = 1'b1;
                req_d       = 1'b1;
            end
        end else begin
            if (rej_hit)
                stat_d.rejected = 1'b1;
            if (scan_hit && stat_d.rejected) begin
                stat_d.rejected = 1'b0;
                if (!masked)
                    req_d = 1'b1;
            end
            if (irq && !irq_q) begin
                if (masked)
                    stat_d.mask_pend = 1'b1;
                else
                    req_d = 1'b1;
            end
            if (masked && req_d) begin
                req_d            = 1'b0;
                stat_d.mask_pend = 1'b1;
            end
            if (cfg_hit && !masked && stat_d.mask_pend) begin
                stat_d.mask_pend = 1'b0;
                req_d            = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            server <= '0;
            prio   <= PRIO_MASKED;
            saved  <= PRIO_MASKED;
            stat_q <= '0;
            req    <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            server <= srv_d;
            prio   <= prio_d;
            saved  <= saved_d;
            stat_q <= stat_d;
            req    <= req_d;
            irq_q  <= irq;
        end
    end
endmodule

// File: rtl/irqsrc_scan.sv
module irqsrc_scan
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC = 8,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               resend,
    output logic [NUM_SRC-1:0] scan_hit,
    output logic               busy
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SRC - 1);

    scan_state_t      st_q, st_d;
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_comb begin
        st_d  = st_q;
        ptr_d = ptr_q;
        unique case (st_q)
            SC_IDLE: begin
                if (resend) begin
                    st_d  = SC_WALK;
                    ptr_d = '0;
                end
            end
            SC_WALK: begin
                if (resend) begin
                    ptr_d = '0;
                end else if (ptr_q == LAST) begin
                    st_d  = SC_IDLE;
                    ptr_d = '0;
                end else begin
                    ptr_d = ptr_q + 1'b1;
                end
            end
            default: st_d = SC_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SC_IDLE;
            ptr_q <= '0;
        end else begin
            st_q  <= st_d;
            ptr_q <= ptr_d;
        end
    end

    always_comb begin
        scan_hit = '0;
        busy     = 1'b0;
        unique case (st_q)
            SC_IDLE: ;
            SC_WALK: begin
                busy            = 1'b1;
                scan_hit[ptr_q] = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/irqsrc_arb.sv
module irqsrc_arb #(
    parameter int NUM_SRC = 8,
    parameter int SRV_W   = 4,
    parameter int NUM_W   = 24,
    parameter int BASE    = 'h1000,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req,
    input  logic [SRV_W-1:0]   server [NUM_SRC],
    input  logic [7:0]         prio   [NUM_SRC],
    output logic [NUM_SRC-1:0] grant,
    output logic               offer_valid,
    output logic [SRV_W-1:0]   offer_server,
    output logic [NUM_W-1:0]   offer_num,
    output logic [7:0]         offer_prio
);
    logic [IDX_W-1:0] sel;
    logic             any;

    always_comb begin
        sel   = '0;
        any   = 1'b0;
        grant = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                sel = IDX_W'(i);
                any = 1'b1;
            end
        end
        if (any)
            grant[sel] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            offer_valid  <= 1'b0;
            offer_server <= '0;
            offer_num    <= '0;
            offer_prio   <= '0;
        end else begin
            offer_valid  <= any;
            offer_server <= server[sel];
            offer_num    <= NUM_W'(BASE) + NUM_W'(sel);
            offer_prio   <= prio[sel];
        end
    end
endmodule

// File: rtl/irq_src_ctl.sv
module irq_src_ctl
    import irqsrc_pkg::*;
#(
    parameter int NUM_SRC                  = 8,
    parameter int SRV_W                    = 4,
    parameter int NUM_W                    = 24,
    parameter int BASE                     = 'h1000,
    parameter logic [NUM_SRC-1:0] LEVEL_MASK = 8'hF0,
    localparam int IDX_W                   = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_in,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [SRV_W-1:0]   cfg_server,
    input  logic [7:0]         cfg_prio,
    input  logic [7:0]         cfg_saved,
    input  logic               rej_valid,
    input  logic [NUM_W-1:0]   rej_num,
    input  logic               eoi_valid,
    input  logic [NUM_W-1:0]   eoi_num,
    input  logic               resend,
    output logic               offer_valid,
    output logic [SRV_W-1:0]   offer_server,
    output logic [NUM_W-1:0]   offer_num,
    output logic [7:0]         offer_prio
);
    logic [NUM_SRC-1:0] req_v, grant_v, scan_hit, mask_v;
    logic [NUM_SRC-1:0] cfg_hit, rej_hit, eoi_hit;
    logic [SRV_W-1:0]   srv_a   [NUM_SRC];
    logic [7:0]         prio_a  [NUM_SRC];
    logic [7:0]         saved_a [NUM_SRC];
    logic               scan_busy;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign cfg_hit[i] = cfg_we && (cfg_idx == IDX_W'(i));
        assign rej_hit[i] = rej_valid && (rej_num == NUM_W'(BASE + i));
        assign eoi_hit[i] = eoi_valid && (eoi_num == NUM_W'(BASE + i));
        assign mask_v[i]  = (prio_a[i] == PRIO_MASKED);

        irqsrc_slot #(
            .SRV_W    (SRV_W),
            .IS_LEVEL (LEVEL_MASK[i])
        ) u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .irq        (irq_in[i]),
            .cfg_hit    (cfg_hit[i]),
            .cfg_server (cfg_server),
            .cfg_prio   (cfg_prio),
            .cfg_saved  (cfg_saved),
            .rej_hit    (rej_hit[i]),
            .eoi_hit    (eoi_hit[i]),
            .scan_hit   (scan_hit[i]),
            .grant      (grant_v[i]),
            .req        (req_v[i]),
            .server     (srv_a[i]),
            .prio       (prio_a[i]),
            .saved      (saved_a[i])
        );
    end

    irqsrc_scan #(.NUM_SRC(NUM_SRC)) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .resend   (resend),
        .scan_hit (scan_hit),
        .busy     (scan_busy)
    );

    irqsrc_arb #(
        .NUM_SRC (NUM_SRC),
        .SRV_W   (SRV_W),
        .NUM_W   (NUM_W),
        .BASE    (BASE)
    ) u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req_v),
        .server       (srv_a),
        .prio         (prio_a),
        .grant        (grant_v),
        .offer_valid  (offer_valid),
        .offer_server (offer_server),
        .offer_num    (offer_num),
        .offer_prio   (offer_prio)
    );
endmodule

// File: rtl/irqsrc_chk.sv
module irqsrc_chk #(
    parameter int NUM_SRC = 8,
    parameter int NUM_W   = 24,
    parameter int BASE    = 'h1000,
    localparam int IDX_W  = $clog2(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               offer_valid,
    input logic [7:0]         offer_prio,
    input logic [NUM_W-1:0]   offer_num,
    input logic [NUM_SRC-1:0] req,
    input logic [NUM_SRC-1:0] masked,
    input logic [NUM_SRC-1:0] scan_hit,
    input logic               cfg_we,
    input logic [IDX_W-1:0]   cfg_idx,
    input logic [7:0]         cfg_saved,
    input logic [7:0]         saved [NUM_SRC]
);
    // R2
    offer_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> offer_prio != 8'hFF);

    // R9
    offer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> (offer_num >= NUM_W'(BASE)) && (offer_num < NUM_W'(BASE + NUM_SRC)));

    // R7
    scan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(scan_hit));

    // R8
    offer_from_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        offer_valid |-> $past(|req));

    // R10
    no_masked_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req & masked) == '0);

    // R11
    saved_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> saved[$past(cfg_idx)] == $past(cfg_saved));
endmodule

bind irq_src_ctl irqsrc_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_W   (NUM_W),
    .BASE    (BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .offer_valid (offer_valid),
    .offer_prio  (offer_prio),
    .offer_num   (offer_num),
    .req         (req_v),
    .masked      (mask_v),
    .scan_hit    (scan_hit),
    .cfg_we      (cfg_we),
    .cfg_idx     (cfg_idx),
    .cfg_saved   (cfg_saved),
    .saved       (saved_a)
);

// File: tb/tb_irq_src_ctl.sv
`timescale 1ns/1ps
module tb_irq_src_ctl;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] irq_in;
    logic        cfg_we;
    logic [2:0]  cfg_idx;
    logic [3:0]  cfg_server;
    logic [7:0]  cfg_prio, cfg_saved;
    logic        rej_valid, eoi_valid, resend;
    logic [23:0] rej_num, eoi_num;
    logic        offer_valid;
    logic [3:0]  offer_server;
    logic [23:0] offer_num;
    logic [7:0]  offer_prio;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irq_src_ctl dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_server(cfg_server),
        .cfg_prio(cfg_prio), .cfg_saved(cfg_saved),
        .rej_valid(rej_valid), .rej_num(rej_num),
        .eoi_valid(eoi_valid), .eoi_num(eoi_num), .resend(resend),
        .offer_valid(offer_valid), .offer_server(offer_server),
        .offer_num(offer_num), .offer_prio(offer_prio)
    );

    // entry: {index[3:0], server[3:0], priority[7:0]}
    localparam logic [15:0] VEC [6] = '{
        16'h0_3_10, 16'h1_9_05, 16'h3_F_FE,
        16'h4_2_00, 16'h6_5_80, 16'h7_1_42
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq_in = '0; cfg_we = 1'b0; cfg_idx = '0;
        cfg_server = '0; cfg_prio = '0; cfg_saved = '0;
        rej_valid = 1'b0; rej_num = '0; eoi_valid = 1'b0; eoi_num = '0;
        resend = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic cfg(input logic [2:0] idx, input logic [3:0] srv, input logic [7:0] pr);
        cfg_we = 1'b1; cfg_idx = idx; cfg_server = srv; cfg_prio = pr; cfg_saved = ~pr;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic reject(input logic [23:0] num);
        rej_valid = 1'b1; rej_num = num; tick(); rej_valid = 1'b0;
    endtask

    task automatic eoi(input logic [23:0] num);
        eoi_valid = 1'b1; eoi_num = num; tick(); eoi_valid = 1'b0;
    endtask

    task automatic do_resend();
        resend = 1'b1; tick(); resend = 1'b0;
    endtask

    task automatic expect_offer(input string tag, input int exp_n, input logic [3:0] srv,
                                input logic [23:0] num, input logic [7:0] pr);
        int n = 0;
        bit found = 0;
        for (int k = 1; k <= 40; k++) begin
            tick();
            if (offer_valid) begin
                n = k; found = 1; break;
            end
        end
        checks++;
        if (!found || n != exp_n || offer_server != srv || offer_num != num || offer_prio != pr) begin
            errors++;
            $display("FAIL %s: got found=%0d after %0d srv=%0h num=%0h prio=%0h, expected after %0d srv=%0h num=%0h prio=%0h",
                     tag, found, n, offer_server, offer_num, offer_prio, exp_n, srv, num, pr);
        end
    endtask

    task automatic expect_none(input string tag, input int cycles);
        bit seen = 0;
        logic [23:0] got = '0;
        for (int k = 0; k < cycles; k++) begin
            tick();
            if (offer_valid && !seen) begin
                seen = 1; got = offer_num;
            end
        end
        checks++;
        if (seen) begin
            errors++;
            $display("FAIL %s: got offer num=%0h, expected no offer", tag, got);
        end
    endtask

    task automatic check_now(input string tag, input logic v, input logic [23:0] num);
        checks++;
        if (offer_valid != v || (v && offer_num != num)) begin
            errors++;
            $display("FAIL %s: got valid=%0d num=%0h, expected valid=%0d num=%0h",
                     tag, offer_valid, offer_num, v, num);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: idle after reset
        check_now("R1", 1'b0, '0);

        // R1/R3: reset leaves sources masked, edge is remembered
        irq_in[2] = 1'b1;
        expect_none("R3", 5);
        irq_in[2] = 1'b0;
        cfg(2, 4'h6, 8'h20);
        expect_offer("R3", 1, 4'h6, 24'h1002, 8'h20);

        // table walk: R2 / R4 / R12
        do_reset();
        for (int v = 0; v < 6; v++) begin
            logic [2:0] idx = VEC[v][14:12];
            logic [3:0] srv = VEC[v][11:8];
            logic [7:0] pr  = VEC[v][7:0];
            bit lvl = (idx >= 3'd4);
            cfg(idx, srv, pr);
            irq_in[idx] = 1'b1;
            expect_offer(lvl ? "R4" : "R2", 2, srv, 24'h1000 + 24'(idx), pr);
            expect_none(lvl ? "R4" : "R2", 3);
            irq_in[idx] = 1'b0;
            tick();
            irq_in[idx] = 1'b1;
            if (lvl) expect_none("R12", 4);
            else     expect_offer("R12", 2, srv, 24'h1000 + 24'(idx), pr);
            irq_in[idx] = 1'b0;
            tick();
            if (lvl) eoi(24'h1000 + 24'(idx));
            expect_none("R12", 3);
        end

        // R8: simultaneous requests, lowest index first
        do_reset();
        cfg(1, 4'h2, 8'h07);
        cfg(3, 4'h4, 8'h06);
        irq_in[1] = 1'b1; irq_in[3] = 1'b1;
        tick(); tick();
        check_now("R8", 1'b1, 24'h1001);
        tick();
        check_now("R8", 1'b1, 24'h1003);
        tick();
        check_now("R8", 1'b0, '0);
        irq_in = '0;

        // R6/R7: message reject then resend replay, once only
        do_reset();
        cfg(2, 4'h5, 8'h05);
        irq_in[2] = 1'b1;
        expect_offer("R2", 2, 4'h5, 24'h1002, 8'h05);
        irq_in[2] = 1'b0;
        reject(24'h1002);
        expect_none("R6", 4);
        eoi(24'h1002);           // R5: EOI must not clear rejected
        do_resend();
        expect_offer("R7", 4, 4'h5, 24'h1002, 8'h05);
        do_resend();
        expect_none("R7", 12);

        // R7: resend restart during a walk
        reject(24'h1003);
        cfg(3, 4'h1, 8'h11);
        do_resend();
        do_resend();
        expect_offer("R7", 5, 4'h1, 24'h1003, 8'h11);

        // R4/R5/R6: level source flow
        do_reset();
        cfg(5, 4'h7, 8'h03);
        irq_in[5] = 1'b1;
        expect_offer("R4", 2, 4'h7, 24'h1005, 8'h03);
        expect_none("R4", 5);
        eoi(24'h1005);
        expect_none("R5", 5);
        do_resend();
        expect_offer("R5", 7, 4'h7, 24'h1005, 8'h03);
        reject(24'h1005);
        expect_none("R6", 3);
        irq_in[5] = 1'b0;
        expect_none("R6", 3);
        irq_in[5] = 1'b1;
        expect_offer("R6", 2, 4'h7, 24'h1005, 8'h03);
        irq_in[5] = 1'b0;

        // R4: configuration write re-evaluates a level source
        do_reset();
        irq_in[6] = 1'b1;
        expect_none("R4", 4);
        cfg(6, 4'h9, 8'h02);
        expect_offer("R4", 1, 4'h9, 24'h1006, 8'h02);
        irq_in[6] = 1'b0;

        // R9: out-of-range reject aliasing source 0 is ignored
        do_reset();
        cfg(0, 4'h3, 8'h01);
        irq_in[0] = 1'b1;
        expect_offer("R9", 2, 4'h3, 24'h1000, 8'h01);
        irq_in[0] = 1'b0;
        reject(24'h1008);
        reject(24'h0FFF);
        do_resend();
        expect_none("R9", 12);

        // R10: masking a queued offer
        do_reset();
        cfg(0, 4'h1, 8'h09);
        cfg(1, 4'h2, 8'h08);
        irq_in[0] = 1'b1; irq_in[1] = 1'b1;
        tick();
        cfg(1, 4'h2, 8'hFF);
        check_now("R10", 1'b1, 24'h1000);
        expect_none("R10", 6);
        cfg(1, 4'hA, 8'h04);
        expect_offer("R10", 1, 4'hA, 24'h1001, 8'h04);
        irq_in = '0;

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule